// File: doc/BRIEF.md
# Thread join and fire scheduler

This block decides when threads become ready to run. It takes three kinds of event: a start request from the local execution unit, a join event from the same unit, and a join message arriving from the network. A start request becomes a fire record at once. A join event counts down a packed join word kept in a small frame memory. When that count runs out, the block fires the thread named in the word and reloads the count, so a thread inside a loop can be fired again. A network join message also stores a returned value into the frame before it performs the join.

Fire records hold a frame pointer and a 26-bit thread start address. They go into a ready queue, which the execution unit drains through a pop strobe. The execution unit sets up join words and reads frame contents through a single-word memory port. A write on that port blocks event processing for that cycle.

Top module: `thread_join_unit`

## Requirements
- R1: After reset the ready queue is empty (`fire_valid` low), `err_zero` is low, all frame words read as zero, and with no memory write and no full queue `msg_ready` is high.
- R2: A join word has this layout: count in bits 31:29, reload value in bits 28:26, thread start address in bits 25:0. For example, 0x4800000E means count 2, reload 2, address 14.
- R3: An accepted start request puts a fire record with its frame pointer and start address into the ready queue. The record is visible on `fire_valid`/`fire_fp`/`fire_ip` in the cycle after acceptance.
- R4: A local join event works on the word at `sync_fp + sync_off`. If the count is above one, the count is lowered by one and nothing is fired.
- R5: A join event that finds a count of one writes the reload value into the count field and fires a record made of the event's frame pointer and the word's start address. The start address and reload fields are not changed.
- R6: An accepted network message writes `msg_value` to `msg_fp + msg_fut_off`. It then joins on the word at `msg_fp + msg_slot_off` exactly as in R4 and R5.
- R7: Only one event is accepted per cycle. A network message wins over a local join event, and a local join event wins over a start request. The losers keep their ready signal low.
- R8: While the ready queue is full, all three ready signals are low. No fire record is ever lost, and records leave the queue in the order they entered.
- R9: A join event that finds a count of zero pulses `err_zero` in the following cycle. It leaves the word unchanged and fires nothing.
- R10: A write on the frame memory port takes effect at the clock edge, and all three ready signals are low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spawn_valid | input | 1 | Start request present |
| spawn_fp | input | ADDR_W | Frame pointer of the start request |
| spawn_ip | input | 26 | Thread start address |
| spawn_ready | output | 1 | Start request accepted this cycle |
| sync_valid | input | 1 | Local join event present |
| sync_fp | input | ADDR_W | Frame pointer of the join |
| sync_off | input | OFF_W | Join word offset within the frame |
| sync_ready | output | 1 | Join event accepted this cycle |
| msg_valid | input | 1 | Network join message present |
| msg_fp | input | ADDR_W | Frame pointer of the message |
| msg_fut_off | input | OFF_W | Offset of the value word |
| msg_slot_off | input | OFF_W | Offset of the join word |
| msg_value | input | 32 | Value to store |
| msg_ready | output | 1 | Message accepted this cycle |
| lm_wr | input | 1 | Frame memory write strobe |
| lm_addr | input | ADDR_W | Frame memory address (read and write) |
| lm_wdata | input | 32 | Frame memory write data |
| lm_rdata | output | 32 | Frame memory read data at `lm_addr` |
| fire_valid | output | 1 | Ready queue not empty |
| fire_fp | output | ADDR_W | Frame pointer at queue head |
| fire_ip | output | 26 | Thread start address at queue head |
| fire_pop | input | 1 | Remove queue head |
| err_zero | output | 1 | Join found a zero count (one-cycle pulse) |

## Verification
A bad count decrement or reload shows up on `lm_rdata` as soon as the join edge has passed. It also shows up on `fire_valid` one cycle later, when a fire is missing or extra. A wrong start address or frame pointer in a join word appears directly on `fire_ip`/`fire_fp` when that record reaches the queue head. Queue pointer or fullness errors show up as lost, repeated or reordered records during draining, or as ready signals that stay high while the queue is full. Arbitration faults show up at once in the combinational ready signals, in the same cycle the competing valids are raised.

// File: rtl/tju_pkg.sv
package tju_pkg;
  localparam int TP_W  = 26;
  localparam int CNT_W = 3;

  typedef struct packed {
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] reload;
    logic [TP_W-1:0]  tp;
  } join_word_t;
endpackage

// File: rtl/tju_join_alu.sv
module tju_join_alu
  import tju_pkg::*;
(
  input  join_word_t cur_i,
  output join_word_t nxt_o,
  output logic       fire_o,
  output logic       zero_o
);
  always_comb begin
    nxt_o  = cur_i;
    fire_o = 1'b0;
    zero_o = 1'b0;
    if (cur_i.cnt == '0) begin
      zero_o = 1'b1;
    end else if (cur_i.cnt == CNT_W'(1)) begin
      nxt_o.cnt = cur_i.reload;
      fire_o    = 1'b1;
    end else begin
      nxt_o.cnt = cur_i.cnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/tju_frame_mem.sv
module tju_frame_mem #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wa_en,
  input  logic [ADDR_W-1:0] wa_addr,
  input  logic [DATA_W-1:0] wa_data,
  input  logic              wb_en,
  input  logic [ADDR_W-1:0] wb_addr,
  input  logic [DATA_W-1:0] wb_data,
  input  logic [ADDR_W-1:0] ra_addr,
  output logic [DATA_W-1:0] ra_data,
  input  logic [ADDR_W-1:0] rb_addr,
  output logic [DATA_W-1:0] rb_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] words [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic              hit_a, hit_b, en_w;
    logic [DATA_W-1:0] d_w;
    always_comb begin
      hit_a = wa_en && (wa_addr == ADDR_W'(g));
      hit_b = wb_en && (wb_addr == ADDR_W'(g));
      en_w  = hit_a || hit_b;
      d_w   = hit_a ? wa_data : wb_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    words[g] <= '0;
      else if (en_w) words[g] <= d_w;
    end
  end

  assign ra_data = words[ra_addr];
  assign rb_data = words[rb_addr];
endmodule

// File: rtl/tju_fire_fifo.sv
module tju_fire_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head_data,
  output logic         not_empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     store [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_pop;

  assign not_empty = (cnt_q != '0);
  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign head_data = store[rd_q];
  assign do_pop    = pop && not_empty;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) wr_d = (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + PTR_W'(1);
    if (do_pop) rd_d = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + PTR_W'(1);
    if (push && !do_pop) cnt_d = cnt_q + CNT_W'(1);
    else if (!push && do_pop) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) store[wr_q] <= push_data;
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/thread_join_unit.sv
module thread_join_unit
  import tju_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int OFF_W      = 3,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spawn_valid,
  input  logic [ADDR_W-1:0] spawn_fp,
  input  logic [25:0]       spawn_ip,
  output logic              spawn_ready,
  input  logic              sync_valid,
  input  logic [ADDR_W-1:0] sync_fp,
  input  logic [OFF_W-1:0]  sync_off,
  output logic              sync_ready,
  input  logic              msg_valid,
  input  logic [ADDR_W-1:0] msg_fp,
  input  logic [OFF_W-1:0]  msg_fut_off,
  input  logic [OFF_W-1:0]  msg_slot_off,
  input  logic [31:0]       msg_value,
  output logic              msg_ready,
  input  logic              lm_wr,
  input  logic [ADDR_W-1:0] lm_addr,
  input  logic [31:0]       lm_wdata,
  output logic [31:0]       lm_rdata,
  output logic              fire_valid,
  output logic [ADDR_W-1:0] fire_fp,
  output logic [25:0]       fire_ip,
  input  logic              fire_pop,
  output logic              err_zero
);
  localparam int REC_W = ADDR_W + TP_W;

  logic              q_full, free_cycle;
  logic              gnt_msg, gnt_sync, gnt_spawn, gnt_join;
  logic [ADDR_W-1:0] ev_fp, slot_addr, fut_addr;
  logic [31:0]       slot_raw;
  join_word_t        slot_cur, slot_nxt;
  logic              hit_fire, hit_zero;
  logic              wa_en;
  logic [ADDR_W-1:0] wa_addr;
  logic [31:0]       wa_data;
  logic              push;
  logic [REC_W-1:0]  push_rec, head_rec;
  logic              err_d, err_q;

  // Fixed-priority arbiter: network, then local join, then start request
  always_comb begin
    free_cycle = !lm_wr && !q_full;
    gnt_msg    = msg_valid && free_cycle;
    gnt_sync   = sync_valid && free_cycle && !msg_valid;
    gnt_spawn  = spawn_valid && free_cycle && !msg_valid && !sync_valid;
    gnt_join   = gnt_msg || gnt_sync;
  end

  assign msg_ready   = gnt_msg;
  assign sync_ready  = gnt_sync;
  assign spawn_ready = gnt_spawn;

  always_comb begin
    ev_fp     = msg_valid ? msg_fp : sync_fp;
    slot_addr = msg_valid ? msg_fp + ADDR_W'(msg_slot_off)
                          : sync_fp + ADDR_W'(sync_off);
    fut_addr  = msg_fp + ADDR_W'(msg_fut_off);
  end

  assign slot_cur = join_word_t'(slot_raw);

  tju_join_alu u_alu (
    .cur_i  (slot_cur),
    .nxt_o  (slot_nxt),
    .fire_o (hit_fire),
    .zero_o (hit_zero)
  );

  // Write port A: memory port has the cycle, otherwise the join result
  always_comb begin
    wa_en   = 1'b0;
    wa_addr = lm_addr;
    wa_data = lm_wdata;
    if (lm_wr) begin
      wa_en = 1'b1;
    end else if (gnt_join && !hit_zero) begin
      wa_en   = 1'b1;
      wa_addr = slot_addr;
      wa_data = 32'(slot_nxt);
    end
  end

  tju_frame_mem #(.ADDR_W(ADDR_W), .DATA_W(32)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .wa_en   (wa_en),
    .wa_addr (wa_addr),
    .wa_data (wa_data),
    .wb_en   (gnt_msg),
    .wb_addr (fut_addr),
    .wb_data (msg_value),
    .ra_addr (slot_addr),
    .ra_data (slot_raw),
    .rb_addr (lm_addr),
    .rb_data (lm_rdata)
  );

  always_comb begin
    push     = gnt_spawn || (gnt_join && hit_fire);
    push_rec = gnt_spawn ? {spawn_fp, spawn_ip} : {ev_fp, slot_cur.tp};
  end

  tju_fire_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (push_rec),
    .pop       (fire_pop),
    .head_data (head_rec),
    .not_empty (fire_valid),
    .full      (q_full)
  );

  assign fire_fp = head_rec[REC_W-1:TP_W];
  assign fire_ip = head_rec[TP_W-1:0];

  assign err_d = gnt_join && hit_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign err_zero = err_q;

  assert_one_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({msg_ready, sync_ready, spawn_ready}));
  assert_msg_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> !sync_ready && !spawn_ready);
  assert_full_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> !(msg_ready || sync_ready || spawn_ready));
  assert_spawn_fires_R3: assert property (@(posedge clk) disable iff (!rst_n)
    spawn_ready |=> fire_valid);
  assert_zero_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_join && slot_cur.cnt == '0) |=> err_zero);
  assert_mem_port_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lm_wr |-> !(msg_ready || sync_ready || spawn_ready));
endmodule

// File: tb/tb_thread_join_unit.sv
module tb_thread_join_unit;
  localparam int ADDR_W = 6;
  localparam int OFF_W  = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              spawn_valid;
  logic [ADDR_W-1:0] spawn_fp;
  logic [25:0]       spawn_ip;
  logic              spawn_ready;
  logic              sync_valid;
  logic [ADDR_W-1:0] sync_fp;
  logic [OFF_W-1:0]  sync_off;
  logic              sync_ready;
  logic              msg_valid;
  logic [ADDR_W-1:0] msg_fp;
  logic [OFF_W-1:0]  msg_fut_off, msg_slot_off;
  logic [31:0]       msg_value;
  logic              msg_ready;
  logic              lm_wr;
  logic [ADDR_W-1:0] lm_addr;
  logic [31:0]       lm_wdata, lm_rdata;
  logic              fire_valid;
  logic [ADDR_W-1:0] fire_fp;
  logic [25:0]       fire_ip;
  logic              fire_pop;
  logic              err_zero;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  thread_join_unit #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .FIFO_DEPTH(4)) dut (.*);

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic mem_write(input int a, input logic [31:0] d);
    @(negedge clk);
    lm_wr = 1; lm_addr = ADDR_W'(a); lm_wdata = d;
    @(posedge clk);
    @(negedge clk);
    lm_wr = 0;
  endtask

  task automatic mem_check(input string req, input int a, input logic [31:0] exp);
    @(negedge clk);
    lm_addr = ADDR_W'(a);
    #1 chk(req, "frame word", 64'(lm_rdata), 64'(exp));
  endtask

  task automatic do_spawn(input string req, input int fp, input int ip);
    @(negedge clk);
    spawn_valid = 1; spawn_fp = ADDR_W'(fp); spawn_ip = 26'(ip);
    #1 chk(req, "spawn_ready", 64'(spawn_ready), 64'(1));
    @(posedge clk);
    @(negedge clk);
    spawn_valid = 0;
  endtask

  task automatic do_sync(input string req, input int fp, input int off);
    @(negedge clk);
    sync_valid = 1; sync_fp = ADDR_W'(fp); sync_off = OFF_W'(off);
    #1 chk(req, "sync_ready", 64'(sync_ready), 64'(1));
    @(posedge clk);
    @(negedge clk);
    sync_valid = 0;
  endtask

  task automatic pop_expect(input string req, input int fp, input int ip);
    @(negedge clk);
    chk(req, "fire_valid", 64'(fire_valid), 64'(1));
    chk(req, "fire_fp", 64'(fire_fp), 64'(fp));
    chk(req, "fire_ip", 64'(fire_ip), 64'(ip));
    fire_pop = 1;
    @(posedge clk);
    @(negedge clk);
    fire_pop = 0;
  endtask

  task automatic expect_empty(input string req);
    @(negedge clk);
    chk(req, "queue empty", 64'(fire_valid), 64'(0));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1", "fire_valid", 64'(fire_valid), 64'(0));
    chk("R1", "err_zero", 64'(err_zero), 64'(0));
    msg_valid = 1;
    #1 chk("R1", "msg_ready", 64'(msg_ready), 64'(1));
    msg_valid = 0;
    lm_addr = 6'd17;
    #1 chk("R1", "word zero", 64'(lm_rdata), 64'(0));
  endtask

  task automatic t_spawn;
    do_spawn("R3", 3, 26'h123);
    pop_expect("R3", 3, 26'h123);
    expect_empty("R3");
  endtask

  task automatic t_join_loop;
    mem_write(15, 32'h4800000E);
    do_sync("R4", 10, 5);
    expect_empty("R4");
    mem_check("R4", 15, 32'h2800000E);
    do_sync("R5", 10, 5);
    mem_check("R5", 15, 32'h4800000E);
    pop_expect("R2", 10, 14);
    do_sync("R5", 10, 5);
    do_sync("R5", 10, 5);
    pop_expect("R5", 10, 14);
  endtask

  task automatic t_message;
    mem_write(25, 32'h24000007);
    @(negedge clk);
    msg_valid = 1; msg_fp = 6'd20; msg_fut_off = 3'd3; msg_slot_off = 3'd5;
    msg_value = 32'hDEADBEEF;
    #1 chk("R6", "msg_ready", 64'(msg_ready), 64'(1));
    @(posedge clk);
    @(negedge clk);
    msg_valid = 0;
    mem_check("R6", 23, 32'hDEADBEEF);
    mem_check("R6", 25, 32'h24000007);
    pop_expect("R6", 20, 7);
  endtask

  task automatic t_zero;
    mem_write(30, 32'h04000009);
    do_sync("R9", 28, 2);
    chk("R9", "err_zero", 64'(err_zero), 64'(1));
    chk("R9", "no fire", 64'(fire_valid), 64'(0));
    mem_check("R9", 30, 32'h04000009);
    @(negedge clk);
    chk("R9", "err pulse ends", 64'(err_zero), 64'(0));
  endtask

  task automatic t_priority;
    mem_write(41, 32'h24000011);
    mem_write(48, 32'h24000022);
    @(negedge clk);
    msg_valid = 1; msg_fp = 6'd40; msg_fut_off = 3'd2; msg_slot_off = 3'd1;
    msg_value = 32'h55;
    sync_valid = 1; sync_fp = 6'd48; sync_off = 3'd0;
    spawn_valid = 1; spawn_fp = 6'd50; spawn_ip = 26'h33;
    #1;
    chk("R7", "msg wins", 64'({msg_ready, sync_ready, spawn_ready}), 64'(3'b100));
    @(posedge clk);
    @(negedge clk);
    msg_valid = 0;
    #1 chk("R7", "sync next", 64'({sync_ready, spawn_ready}), 64'(2'b10));
    @(posedge clk);
    @(negedge clk);
    sync_valid = 0;
    #1 chk("R7", "spawn last", 64'(spawn_ready), 64'(1));
    @(posedge clk);
    @(negedge clk);
    spawn_valid = 0;
    pop_expect("R7", 40, 26'h11);
    pop_expect("R7", 48, 26'h22);
    pop_expect("R7", 50, 26'h33);
  endtask

  task automatic t_full;
    for (int i = 1; i <= 4; i++) do_spawn("R8", i, 26'h100 + i);
    @(negedge clk);
    spawn_valid = 1; spawn_fp = 6'd5; spawn_ip = 26'h105;
    sync_valid = 0; msg_valid = 1; msg_fp = 6'd40; msg_slot_off = 3'd1;
    #1 chk("R8", "stalled when full", 64'({msg_ready, spawn_ready}), 64'(0));
    msg_valid = 0;
    @(posedge clk);
    @(negedge clk);
    fire_pop = 1;
    #1 chk("R8", "still full during pop", 64'(spawn_ready), 64'(0));
    @(posedge clk);
    @(negedge clk);
    fire_pop = 0;
    #1 chk("R8", "resumes", 64'(spawn_ready), 64'(1));
    @(posedge clk);
    @(negedge clk);
    spawn_valid = 0;
    for (int i = 2; i <= 5; i++) pop_expect("R8", i, 26'h100 + i);
    expect_empty("R8");
  endtask

  task automatic t_memport;
    @(negedge clk);
    lm_wr = 1; lm_addr = 6'd60; lm_wdata = 32'h24000044;
    sync_valid = 1; sync_fp = 6'd60; sync_off = 3'd0;
    #1 chk("R10", "join blocked", 64'(sync_ready), 64'(0));
    @(posedge clk);
    @(negedge clk);
    lm_wr = 0;
    #1 chk("R10", "join accepted after", 64'(sync_ready), 64'(1));
    @(posedge clk);
    @(negedge clk);
    sync_valid = 0;
    pop_expect("R10", 60, 26'h44);
  endtask

  initial begin
    rst_n = 0;
    spawn_valid = 0; spawn_fp = '0; spawn_ip = '0;
    sync_valid = 0; sync_fp = '0; sync_off = '0;
    msg_valid = 0; msg_fp = '0; msg_fut_off = '0; msg_slot_off = '0; msg_value = '0;
    lm_wr = 0; lm_addr = '0; lm_wdata = '0; fire_pop = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    t_reset();
    t_spawn();
    t_join_loop();
    t_message();
    t_zero();
    t_priority();
    t_full();
    t_memport();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule